// File: doc/BRIEF.md
# Chaotic Keystream Pixel Cipher

This block scrambles a stream of 24-bit colour pixels. For every pixel it accepts, it forms three key bytes, one per colour channel, from three state words that an external chaotic generator supplies. It XORs each channel with its key byte and then asks the generator for its next step. Each state word is a fixed-point number whose low part is a fractional field. The key byte for a channel is the top byte of that fractional field, rotated left.

XOR is its own inverse, so one instance serves as the transmitter and another as the receiver. The receiver is fed by a generator that is kept synchronized with the transmitter's. Start-of-frame and end-of-line markers travel alongside each pixel. A column and row counter marks the last pixel of a frame on the output.

The pipeline is two registers deep and freezes as a whole when the downstream side withholds ready.

Top module: `chaos_pixel_xor`

## Requirements
- R1: The key byte for a channel is state bits [23:16] (the top byte of the 24-bit fractional field), rotated left by 3. With b = state[23:16], the key is {b[4:0], b[7:5]}.
- R2: Pixel bits [23:16] hold the red channel and take their key from `stateR`. Bits [15:8] hold green and use `stateG`. Bits [7:0] hold blue and use `stateB`.
- R3: Each output channel equals the accepted input channel XOR its key byte. The key comes from the states present in the cycle the pixel is accepted. The result appears with `outValid` two ready-high clock edges after acceptance, and pixels leave in the order they were accepted.
- R4: Feeding the ciphertext back through the block with the same state sequence returns the original pixels.
- R5: A pixel is accepted when `inValid` and `outReady` are both high. `keyStep` is high in exactly those cycles, and `inReady` equals `outReady`.
- R6: While `outReady` is low, the block accepts nothing, does not raise `keyStep`, and holds `outPixel`, `outValid` and the output markers unchanged.
- R7: `outSof` and `outEol` carry the start-of-frame and end-of-line markers of the accepted pixel, with the same latency as the pixel.
- R8: `outEof` is high with the pixel at position COLS*ROWS-1 of a frame. A pixel flagged start-of-frame is position 0. After the last position, counting wraps to 0 even without a new start-of-frame.
- R9: A start-of-frame marker arriving in the middle of a frame restarts the position count at 0 for that pixel.
- R10: After reset, `outValid`, `outEof` and `keyStep` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block can take a pixel this cycle |
| inPixel | input | 24 | Input pixel, R in the top byte |
| inSof | input | 1 | Input pixel is the first of a frame |
| inEol | input | 1 | Input pixel ends a line |
| stateR | input | STATE_W | Chaotic state keying the red channel |
| stateG | input | STATE_W | Chaotic state keying the green channel |
| stateB | input | STATE_W | Chaotic state keying the blue channel |
| keyStep | output | 1 | Request one generator step (pixel accepted) |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Downstream accepts output |
| outPixel | output | 24 | Transformed pixel |
| outSof | output | 1 | Delayed start-of-frame marker |
| outEol | output | 1 | Delayed end-of-line marker |
| outEof | output | 1 | Output pixel is the last of a frame |

## Verification
The bench first applies directed patterns. A zero pixel with state bits set in only one channel separates rotation and byte-selection errors (R1) from errors in the channel-to-state wiring (R2). A ciphertext round trip with a recorded state sequence shows that encryption and decryption are the same path (R4). A full frame that wraps without a new start-of-frame, and a frame cut short by an early start-of-frame, separate the counter's wrap logic from its restart logic. A long random run then mixes random pixels, states, bubbles and ready stalls. It compares every output against a bench-side model of keys, markers, frame position and stall-adjusted latency, so it exposes reordering, dropped or duplicated pixels, and any advance during a stall.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic adv;   // whole pipeline shifts by one slot
    logic take;  // a new pixel is accepted into the first slot
  } pxcStrobe_t;

endpackage

// File: rtl/pxc_ctrl.sv
module pxc_ctrl
  import pxc_pkg::*;
#(
  parameter int COLS = 800,
  parameter int ROWS = 480
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEol,
  input  logic       outReady,
  output logic       inReady,
  output logic       keyStep,
  output pxcStrobe_t strb,
  output logic       outValid,
  output logic       outSof,
  output logic       outEol,
  output logic       outEof
);

  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic accept;
  logic [COL_W-1:0] colCnt, curCol, nextCol;
  logic [ROW_W-1:0] rowCnt, curRow, nextRow;
  logic atFrameEnd;
  logic v1, sof1, eol1, eof1;
  logic v2, sof2, eol2, eof2;

  assign accept  = inValid & outReady;
  assign inReady = outReady;
  assign keyStep = accept;
  assign strb.adv  = outReady;
  assign strb.take = accept;

  // Position of the pixel being accepted; a start-of-frame forces position 0
  always_comb begin
    curCol = inSof ? '0 : colCnt;
    curRow = inSof ? '0 : rowCnt;
    atFrameEnd = (curCol == LAST_COL) && (curRow == LAST_ROW);
    if (atFrameEnd) begin
      nextCol = '0;
      nextRow = '0;
    end else if (curCol == LAST_COL) begin
      nextCol = '0;
      nextRow = curRow + 1'b1;
    end else begin
      nextCol = curCol + 1'b1;
      nextRow = curRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (accept) begin
      colCnt <= nextCol;
      rowCnt <= nextRow;
    end
  end

  // Two-slot marker pipeline, frozen as a whole while outReady is low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0; sof1 <= 1'b0; eol1 <= 1'b0; eof1 <= 1'b0;
      v2 <= 1'b0; sof2 <= 1'b0; eol2 <= 1'b0; eof2 <= 1'b0;
    end else if (strb.adv) begin
      v1   <= inValid;
      sof1 <= inValid & inSof;
      eol1 <= inValid & inEol;
      eof1 <= inValid & atFrameEnd;
      v2   <= v1;
      sof2 <= sof1;
      eol2 <= eol1;
      eof2 <= eof1;
    end
  end

  assign outValid = v2;
  assign outSof   = sof2;
  assign outEol   = eol2;
  assign outEof   = eof2;

  // R8: the position counters never leave the frame
  p_pos_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(colCnt) < COLS) && (int'(rowCnt) < ROWS));

  // R3: an accepted pixel occupies the first slot on the next edge
  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> v1);

  // R6: output handshake and markers frozen across a stall
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |=> ($stable(v2) && $stable(sof2) && $stable(eol2) && $stable(eof2)));

  // R8: end-of-frame only ever rides on a valid pixel
  p_eof_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    eof2 |-> v2);

  generate
    if (COLS > 1) begin : g_restart_chk
      // R9: start-of-frame pixel is position 0, so the next one is column 1
      p_sof_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
        (accept && inSof) |=> (colCnt == COL_W'(1) && rowCnt == '0));
    end
  endgenerate

endmodule

// File: rtl/pxc_datapath.sv
module pxc_datapath
  import pxc_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int CH_W     = 8,
  parameter int STATE_W  = 32,
  parameter int FRAC_W   = 24,
  parameter int KEY_ROT  = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  pxcStrobe_t                           strb,
  input  logic [CHANNELS*CH_W-1:0]             inPixel,
  input  logic [CHANNELS-1:0][STATE_W-1:0]     states,
  output logic [CHANNELS*CH_W-1:0]             outPixel
);

  localparam int PIX_W   = CHANNELS * CH_W;
  localparam int KEY_LSB = FRAC_W - CH_W;

  logic [PIX_W-1:0] keyWord;
  logic [PIX_W-1:0] pix1, key1, pix2;
  logic unusedStateBits;

  assign unusedStateBits = ^states;

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      logic [CH_W-1:0] raw;
      assign raw = states[c][KEY_LSB +: CH_W];
      assign keyWord[c*CH_W +: CH_W] = (raw << KEY_ROT) | (raw >> (CH_W - KEY_ROT));
    end
  endgenerate

  // Slot 1 holds pixel and key of the accepted pixel; slot 2 holds the result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pix1 <= '0;
      key1 <= '0;
      pix2 <= '0;
    end else begin
      if (strb.take) begin
        pix1 <= inPixel;
        key1 <= keyWord;
      end
      if (strb.adv) begin
        pix2 <= pix1 ^ key1;
      end
    end
  end

  assign outPixel = pix2;

  // R6: output data frozen while the pipeline is stalled
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv |=> $stable(pix2));

  // R3: the first slot only changes on an acceptance
  p_slot_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> ($stable(pix1) && $stable(key1)));

endmodule

// File: rtl/chaos_pixel_xor.sv
module chaos_pixel_xor
  import pxc_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int FRAC_W  = 24,
  parameter int KEY_ROT = 3,
  parameter int COLS    = 800,
  parameter int ROWS    = 480
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [23:0]        inPixel,
  input  logic               inSof,
  input  logic               inEol,
  input  logic [STATE_W-1:0] stateR,
  input  logic [STATE_W-1:0] stateG,
  input  logic [STATE_W-1:0] stateB,
  output logic               keyStep,
  output logic               outValid,
  input  logic               outReady,
  output logic [23:0]        outPixel,
  output logic               outSof,
  output logic               outEol,
  output logic               outEof
);

  localparam int CHANNELS = 3;
  localparam int CH_W     = 8;

  pxcStrobe_t strb;
  logic [CHANNELS-1:0][STATE_W-1:0] stateVec;

  // Index 2 keys the top byte (red), index 0 the bottom byte (blue)
  assign stateVec = {stateR, stateG, stateB};

  pxc_ctrl #(
    .COLS(COLS),
    .ROWS(ROWS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSof    (inSof),
    .inEol    (inEol),
    .outReady (outReady),
    .inReady  (inReady),
    .keyStep  (keyStep),
    .strb     (strb),
    .outValid (outValid),
    .outSof   (outSof),
    .outEol   (outEol),
    .outEof   (outEof)
  );

  pxc_datapath #(
    .CHANNELS (CHANNELS),
    .CH_W     (CH_W),
    .STATE_W  (STATE_W),
    .FRAC_W   (FRAC_W),
    .KEY_ROT  (KEY_ROT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inPixel  (inPixel),
    .states   (stateVec),
    .outPixel (outPixel)
  );

endmodule

// File: tb/chaos_pixel_xor_tb.sv
module chaos_pixel_xor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int COLS = 8;
  localparam int ROWS = 4;
  localparam int NPIX = COLS * ROWS;
  localparam int QD = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEol = 1'b0, outReady = 1'b0;
  logic [23:0] inPixel = '0;
  logic [31:0] stateR = '0, stateG = '0, stateB = '0;
  logic inReady, keyStep, outValid, outSof, outEol, outEof;
  logic [23:0] outPixel;

  always #(CLK_PERIOD/2) clk = ~clk;

  chaos_pixel_xor #(.COLS(COLS), .ROWS(ROWS)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPixel(inPixel), .inSof(inSof), .inEol(inEol),
    .stateR(stateR), .stateG(stateG), .stateB(stateB),
    .keyStep(keyStep), .outValid(outValid), .outReady(outReady),
    .outPixel(outPixel), .outSof(outSof), .outEol(outEol), .outEof(outEof)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected-output queue
  logic [23:0] qPix [QD];
  logic        qSof [QD], qEol [QD], qEof [QD];
  int          qStep[QD], qLow[QD];
  int qHead = 0, qTail = 0, qCount = 0;

  // captured outputs
  logic [23:0] capPix [512];
  logic        capEof [512];
  int capN = 0;

  int stepIdx = 0, lowCnt = 0, frameIdx = 0;
  logic lastRdy = 1'b1, lastVal = 1'b0;
  logic [23:0] lastPix = '0;

  function automatic logic [7:0] keyOf(input logic [31:0] s);
    return {s[20:16], s[23:21]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [23:0] pix, input logic sof,
                      input logic eol, input logic rdy,
                      input logic [31:0] sR, input logic [31:0] sG, input logic [31:0] sB);
    inValid = v; inPixel = pix; inSof = sof; inEol = eol; outReady = rdy;
    stateR = sR; stateG = sG; stateB = sB;
    #1;
    chk(keyStep === (v & rdy) && inReady === rdy, "R5", "keyStep/inReady",
        {30'd0, inReady, keyStep}, {30'd0, rdy, v & rdy});
    if (!lastRdy && stepIdx > 0)
      chk(outPixel === lastPix && outValid === lastVal, "R6", "held output",
          {7'd0, outValid, outPixel}, {7'd0, lastVal, lastPix});
    if (outValid === 1'b1 && rdy) begin
      if (qCount == 0) begin
        chk(1'b0, "R3", "unexpected output", {8'd0, outPixel}, 32'd0);
      end else begin
        chk(outPixel === qPix[qHead], "R3", "pixel", {8'd0, outPixel}, {8'd0, qPix[qHead]});
        chk(outSof === qSof[qHead] && outEol === qEol[qHead], "R7", "markers",
            {30'd0, outSof, outEol}, {30'd0, qSof[qHead], qEol[qHead]});
        chk(outEof === qEof[qHead], "R8", "end of frame", {31'd0, outEof}, {31'd0, qEof[qHead]});
        chk(stepIdx - qStep[qHead] == 2 + (lowCnt - qLow[qHead]), "R3", "latency",
            stepIdx - qStep[qHead], 2 + (lowCnt - qLow[qHead]));
        qHead = (qHead + 1) % QD; qCount--;
      end
      capPix[capN] = outPixel; capEof[capN] = outEof; capN++;
    end
    if (v && rdy) begin
      if (sof) frameIdx = 0;
      qPix[qTail] = pix ^ {keyOf(sR), keyOf(sG), keyOf(sB)};
      qSof[qTail] = sof; qEol[qTail] = eol;
      qEof[qTail] = (frameIdx == NPIX - 1);
      qStep[qTail] = stepIdx; qLow[qTail] = lowCnt;
      qTail = (qTail + 1) % QD; qCount++;
      frameIdx = (frameIdx == NPIX - 1) ? 0 : frameIdx + 1;
    end
    lastRdy = rdy; lastPix = outPixel; lastVal = outValid;
    if (!rdy) lowCnt++;
    stepIdx++;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b0, 24'h0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [23:0] plain [16];
  logic [31:0] stA [16], stB [16], stC [16];
  int base;
  int seedSink;

  initial begin
    seedSink = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(outValid === 1'b0 && outEof === 1'b0 && keyStep === 1'b0, "R10", "reset state",
        {29'd0, outValid, outEof, keyStep}, 32'd0);
    @(negedge clk);

    // R1: zero pixel exposes the key bytes; 0xA5 rotated left 3 = 0x2D
    step(1'b1, 24'h0, 1'b1, 1'b0, 1'b1, 32'h00A5_0000, 32'h0080_0000, 32'h0001_0000);
    drain();
    chk(capPix[capN-1] === 24'h2D_04_08, "R1", "key byte rotation", {8'd0, capPix[capN-1]}, 32'h002D0408);

    // R2: only the green state carries key bits; red and blue bytes pass through
    step(1'b1, 24'h123456, 1'b0, 1'b0, 1'b1, 32'hFF00_FFFF, 32'h00FF_0000, 32'hFF00_FFFF);
    drain();
    chk(capPix[capN-1] === 24'h12CB56, "R2", "channel mapping", {8'd0, capPix[capN-1]}, 32'h0012CB56);

    // R4: encrypt a short run, then decrypt it with the same state sequence
    for (int i = 0; i < 16; i++) begin
      plain[i] = 24'($urandom); stA[i] = $urandom; stB[i] = $urandom; stC[i] = $urandom;
    end
    base = capN;
    for (int i = 0; i < 16; i++) step(1'b1, plain[i], i == 0, 1'b0, 1'b1, stA[i], stB[i], stC[i]);
    drain();
    for (int i = 0; i < 16; i++) step(1'b1, capPix[base + i], i == 0, 1'b0, 1'b1, stA[i], stB[i], stC[i]);
    drain();
    for (int i = 0; i < 16; i++)
      chk(capPix[base + 16 + i] === plain[i], "R4", "round trip", {8'd0, capPix[base + 16 + i]}, {8'd0, plain[i]});

    // R8: one full frame then a wrapped frame with no start marker
    base = capN;
    for (int i = 0; i < 2 * NPIX; i++)
      step(1'b1, 24'($urandom), i == 0, (i % COLS) == COLS - 1, 1'b1, $urandom, $urandom, $urandom);
    drain();
    chk(capEof[base + NPIX - 1] === 1'b1 && capEof[base + 2*NPIX - 1] === 1'b1, "R8", "wrap eof",
        {30'd0, capEof[base + NPIX - 1], capEof[base + 2*NPIX - 1]}, 32'd3);

    // R9: restart in mid-frame; eof lands NPIX-1 pixels after the new start
    base = capN;
    for (int i = 0; i < 5 + NPIX; i++)
      step(1'b1, 24'($urandom), (i == 0) || (i == 5), 1'b0, 1'b1, $urandom, $urandom, $urandom);
    drain();
    chk(capEof[base + 5 + NPIX - 1] === 1'b1 && capEof[base + NPIX - 1] === 1'b0, "R9", "restart",
        {30'd0, capEof[base + 5 + NPIX - 1], capEof[base + NPIX - 1]}, 32'd2);

    // R6: long stall with a pixel waiting at the output
    step(1'b1, 24'hABCDEF, 1'b1, 1'b0, 1'b1, $urandom, $urandom, $urandom);
    step(1'b1, 24'h010203, 1'b0, 1'b0, 1'b1, $urandom, $urandom, $urandom);
    for (int i = 0; i < 8; i++) step(1'b1, 24'($urandom), 1'b0, 1'b0, 1'b0, $urandom, $urandom, $urandom);
    drain();

    // Random traffic with bubbles, stalls and sporadic start markers
    capN = 0;
    for (int i = 0; i < 4000; i++) begin
      if (capN > 400) capN = 0;
      step(($urandom % 4) != 0, 24'($urandom), ($urandom % 50) == 0, ($urandom % 8) == 0,
           ($urandom % 5) != 0, $urandom, $urandom, $urandom);
    end
    drain();
    chk(qCount == 0, "R3", "all pixels delivered", qCount, 0);

    finish_run();
  end

endmodule